// File: doc/BRIEF.md
# Same-L1-Set Aware L2 Victim Selector

This block picks the way to evict from one L2 set when an L2 miss needs room for a new line. It works in an inclusive two-level hierarchy. Evicting an L2 line knocks out its L1 copy, and the incoming line may then push out a second block in a different L1 set. To avoid that double eviction, the selector prefers to evict an L2 way whose line occupies the same L1 set as the incoming line. The incoming line will displace something in that L1 set anyway.

Each L2 way keeps the L1 set index of its line next to its tag. A lookup strobe marks the point where L1 has missed and the L2 access starts. In that cycle, the incoming L1 set index is compared against every way's stored index. The match vector, the valid bits and the recency order are registered together with the tag-compare stage. The registered values are held until the L2 outcome arrives, one or more cycles later. On a miss, a purely combinational walk over the registered values yields the victim in the resolving cycle. The walk never lengthens the lookup itself.

An empty way wins first. Otherwise the walk climbs the recency stack from the least-recent end and takes the first way whose L1 set matches. The most-recent way is excluded. If nothing qualifies, the plain LRU way is evicted.

Top module: `l2_victim_sel`

## Requirements
- R1: All selection inputs (valid bits, stored L1 indices, recency order, incoming L1 index) are sampled in the cycle `lookup_vld` is high. Changes to them afterwards do not alter the victim reported at resolution.
- R2: `victim_vld` is high exactly in a cycle where `resolve_vld` and `resolve_miss` are both high and a lookup is pending. It is low in every other cycle.
- R3: A resolution with `resolve_miss` low (an L2 hit) produces no victim and clears the pending lookup. A later miss resolution without a new lookup then produces no victim.
- R4: If any captured way is invalid, the victim is the lowest-numbered invalid way and `victim_src` is 2, regardless of any set match.
- R5: With all ways valid, if the LRU way's stored L1 index equals the incoming index, that way is the victim and `victim_src` is 1.
- R6: `rank_order` holds WAYS slots of way numbers, where slot k sits at bits [k*WAY_W +: WAY_W] and slot 0 is the LRU way. When the LRU way does not match, the victim is the way in the lowest-numbered matching slot below slot WAYS-1, and `victim_src` is 1.
- R7: The way in slot WAYS-1 (the MRU way) is never chosen by a set match. If it is the only matching way, the slot-0 way is evicted and `victim_src` is 0.
- R8: With all ways valid and no way matching, the slot-0 way is the victim and `victim_src` is 0.
- R9: During and after reset, no lookup is pending and `victim_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_vld | input | 1 | L1 missed and an L2 access starts; samples the selection inputs |
| in_l1_idx | input | L1_IDX_W | L1 set index of the incoming line |
| way_valid | input | WAYS | Valid bit per L2 way of the addressed set |
| way_l1_idx | input | WAYS*L1_IDX_W | Stored L1 set index per way, way w at [w*L1_IDX_W +: L1_IDX_W] |
| rank_order | input | WAYS*WAY_W | Recency stack, slot 0 = LRU, slot WAYS-1 = MRU |
| resolve_vld | input | 1 | L2 tag comparison outcome is available |
| resolve_miss | input | 1 | Outcome is a miss (valid with resolve_vld) |
| victim_vld | output | 1 | Victim way is valid this cycle |
| victim_way | output | WAY_W | Chosen victim way |
| victim_src | output | 2 | 0 = LRU fallback, 1 = same-L1-set match, 2 = empty way |

## Verification
The bench builds the block with four ways and a three-bit L1 index. With four ways, every recency slot can be reached by hand-written vectors: the LRU slot, the middle slots and the excluded MRU slot. The narrow index keeps stored and incoming indices easy to align or separate on purpose. In every resolving cycle, the bench drives the selection inputs to altered values. A victim that is not drawn from the values sampled at lookup therefore shows up as a miscompare. Hit resolutions, stray miss resolutions and the cycles after reset probe when no victim may appear.

// File: rtl/l2vs_pkg.sv
package l2vs_pkg;
  typedef enum logic [1:0] {
    SRC_LRU   = 2'd0,
    SRC_SAME  = 2'd1,
    SRC_EMPTY = 2'd2
  } vsrc_e;
endpackage

// File: rtl/l2vs_capture.sv
// Tag-compare stage: per-way L1 set compare and capture of selection state.
module l2vs_capture #(
  parameter int WAYS     = 8,
  parameter int L1_IDX_W = 6,
  parameter int WAY_W    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lookup_vld,
  input  logic                     resolve_vld,
  input  logic [L1_IDX_W-1:0]      in_l1_idx,
  input  logic [WAYS-1:0]          way_valid,
  input  logic [WAYS*L1_IDX_W-1:0] way_l1_idx,
  input  logic [WAYS*WAY_W-1:0]    rank_order,
  output logic                     armed_q,
  output logic [WAYS-1:0]          match_q,
  output logic [WAYS-1:0]          valid_q,
  output logic [WAYS*WAY_W-1:0]    rank_q
);
  logic [WAYS-1:0] match_d;
  logic            armed_d;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_d[w] = (way_l1_idx[w*L1_IDX_W +: L1_IDX_W] == in_l1_idx);
  end

  always_comb begin
    armed_d = armed_q;
    if (resolve_vld) armed_d = 1'b0;
    if (lookup_vld)  armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      valid_q <= '0;
      rank_q  <= '0;
    end else if (lookup_vld) begin
      match_q <= match_d;
      valid_q <= way_valid;
      rank_q  <= rank_order;
    end
  end
endmodule

// File: rtl/l2vs_walk.sv
// Combinational victim choice from the captured state.
module l2vs_walk #(
  parameter int WAYS  = 8,
  parameter int WAY_W = 3
) (
  input  logic [WAYS-1:0]       match_q,
  input  logic [WAYS-1:0]       valid_q,
  input  logic [WAYS*WAY_W-1:0] rank_q,
  output logic [WAY_W-1:0]      pick_way,
  output l2vs_pkg::vsrc_e       pick_src
);
  logic [WAY_W-1:0] slot [WAYS];
  logic             empty_hit;
  logic [WAY_W-1:0] empty_way;
  logic             same_hit;
  logic [WAY_W-1:0] same_way;

  for (genvar k = 0; k < WAYS; k++) begin : g_slot
    assign slot[k] = rank_q[k*WAY_W +: WAY_W];
  end

  // Lowest-numbered empty way.
  always_comb begin
    empty_hit = 1'b0;
    empty_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (!valid_q[w]) begin
        empty_hit = 1'b1;
        empty_way = WAY_W'(w);
      end
    end
  end

  // Walk from the LRU slot upward, stopping short of the MRU slot.
  always_comb begin
    same_hit = 1'b0;
    same_way = slot[0];
    for (int k = WAYS-2; k >= 0; k--) begin
      if (match_q[slot[k]]) begin
        same_hit = 1'b1;
        same_way = slot[k];
      end
    end
  end

  always_comb begin
    if (empty_hit) begin
      pick_way = empty_way;
      pick_src = l2vs_pkg::SRC_EMPTY;
    end else if (same_hit) begin
      pick_way = same_way;
      pick_src = l2vs_pkg::SRC_SAME;
    end else begin
      pick_way = slot[0];
      pick_src = l2vs_pkg::SRC_LRU;
    end
  end
endmodule

// File: rtl/l2_victim_sel.sv
module l2_victim_sel #(
  parameter int WAYS     = 8,
  parameter int L1_IDX_W = 6,
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lookup_vld,
  input  logic [L1_IDX_W-1:0]      in_l1_idx,
  input  logic [WAYS-1:0]          way_valid,
  input  logic [WAYS*L1_IDX_W-1:0] way_l1_idx,
  input  logic [WAYS*WAY_W-1:0]    rank_order,
  input  logic                     resolve_vld,
  input  logic                     resolve_miss,
  output logic                     victim_vld,
  output logic [WAY_W-1:0]         victim_way,
  output logic [1:0]               victim_src
);
  logic                  armed_q;
  logic [WAYS-1:0]       match_q;
  logic [WAYS-1:0]       valid_q;
  logic [WAYS*WAY_W-1:0] rank_q;
  l2vs_pkg::vsrc_e       pick_src;

  l2vs_capture #(.WAYS(WAYS), .L1_IDX_W(L1_IDX_W), .WAY_W(WAY_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .lookup_vld(lookup_vld), .resolve_vld(resolve_vld),
    .in_l1_idx(in_l1_idx), .way_valid(way_valid), .way_l1_idx(way_l1_idx),
    .rank_order(rank_order), .armed_q(armed_q), .match_q(match_q),
    .valid_q(valid_q), .rank_q(rank_q)
  );

  l2vs_walk #(.WAYS(WAYS), .WAY_W(WAY_W)) walk_i (
    .match_q(match_q), .valid_q(valid_q), .rank_q(rank_q),
    .pick_way(victim_way), .pick_src(pick_src)
  );

  assign victim_vld = armed_q & resolve_vld & resolve_miss;
  assign victim_src = pick_src;
endmodule

// File: rtl/l2vs_checker.sv
module l2vs_checker #(
  parameter int WAYS  = 8,
  parameter int WAY_W = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  lookup_vld,
  input logic                  resolve_vld,
  input logic                  resolve_miss,
  input logic                  armed_q,
  input logic [WAYS-1:0]       valid_q,
  input logic [WAYS*WAY_W-1:0] rank_q,
  input logic                  victim_vld,
  input logic [WAY_W-1:0]      victim_way,
  input logic [1:0]            victim_src
);
  a_r2_vld_needs_pending_miss: assert property (@(posedge clk) disable iff (!rst_n)
    victim_vld |-> (resolve_vld && resolve_miss && armed_q));

  a_r1_lookup_arms: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_vld |=> armed_q);

  a_r3_resolve_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_vld && !lookup_vld) |=> !armed_q);

  a_r4_empty_is_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_vld && victim_src == 2'd2) |-> !valid_q[victim_way]);

  a_r7_mru_not_matched: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_vld && victim_src == 2'd1) |-> (victim_way != rank_q[(WAYS-1)*WAY_W +: WAY_W]));

  a_r8_src_legal: assert property (@(posedge clk) disable iff (!rst_n)
    victim_vld |-> (victim_src != 2'd3));

  a_r9_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !armed_q);
endmodule

bind l2_victim_sel l2vs_checker #(.WAYS(WAYS), .WAY_W(WAY_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .lookup_vld(lookup_vld), .resolve_vld(resolve_vld),
  .resolve_miss(resolve_miss), .armed_q(armed_q), .valid_q(valid_q), .rank_q(rank_q),
  .victim_vld(victim_vld), .victim_way(victim_way), .victim_src(victim_src)
);

// File: tb/l2_victim_sel_tb_top.sv
module l2_victim_sel_tb_top;
  localparam int CLK_T = 10;
  localparam int WAYS  = 4;
  localparam int IDX_W = 3;
  localparam int WAY_W = 2;

  logic                  clk;
  logic                  rst_n;
  logic                  lookup_vld;
  logic [IDX_W-1:0]      in_l1_idx;
  logic [WAYS-1:0]       way_valid;
  logic [WAYS*IDX_W-1:0] way_l1_idx;
  logic [WAYS*WAY_W-1:0] rank_order;
  logic                  resolve_vld;
  logic                  resolve_miss;
  logic                  victim_vld;
  logic [WAY_W-1:0]      victim_way;
  logic [1:0]            victim_src;

  typedef struct {
    logic       vld;
    logic [1:0] way;
    logic [1:0] src;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  l2_victim_sel #(.WAYS(WAYS), .L1_IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .lookup_vld(lookup_vld), .in_l1_idx(in_l1_idx),
    .way_valid(way_valid), .way_l1_idx(way_l1_idx), .rank_order(rank_order),
    .resolve_vld(resolve_vld), .resolve_miss(resolve_miss),
    .victim_vld(victim_vld), .victim_way(victim_way), .victim_src(victim_src)
  );

  initial clk = 1'b0;
  always #(CLK_T/2) clk = ~clk;

  function automatic logic [7:0] ord(input logic [1:0] a, input logic [1:0] b,
                                     input logic [1:0] c, input logic [1:0] d);
    return {d, c, b, a};
  endfunction

  function automatic logic [11:0] idx(input logic [2:0] a, input logic [2:0] b,
                                      input logic [2:0] c, input logic [2:0] d);
    return {d, c, b, a};
  endfunction

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic v, input logic [1:0] w, input logic [1:0] s, input string tag);
    exp_t e;
    e.vld = v; e.way = w; e.src = s; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Lookup, then resolve one cycle later with the selection inputs scrambled (R1).
  task automatic run_vec(input logic [3:0] vm, input logic [7:0] ro, input logic [11:0] ix,
                         input logic [2:0] in_ix, input logic miss, input logic ev,
                         input logic [1:0] ew, input logic [1:0] es, input string tag);
    @(negedge clk);
    lookup_vld = 1'b1; way_valid = vm; rank_order = ro; way_l1_idx = ix; in_l1_idx = in_ix;
    @(negedge clk);
    lookup_vld = 1'b0;
    way_valid = '0; rank_order = ~ro; way_l1_idx = ~ix; in_l1_idx = ~in_ix;
    push(ev, ew, es, tag);
    resolve_vld = 1'b1; resolve_miss = miss;
    @(negedge clk);
    resolve_vld = 1'b0;
  endtask

  task automatic resolve_only(input logic miss, input string tag);
    @(negedge clk);
    push(1'b0, 2'd0, 2'd0, tag);
    resolve_vld = 1'b1; resolve_miss = miss;
    @(negedge clk);
    resolve_vld = 1'b0;
  endtask

  // Monitor: compare in every resolving cycle, away from the clock edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (resolve_vld) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL scoreboard: actual result with no expectation, expected none");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({e.tag, " vld"}, {1'b0, victim_vld}, {1'b0, e.vld});
          if (e.vld) begin
            check({e.tag, " way"}, victim_way, e.way);
            check({e.tag, " src"}, victim_src, e.src);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_T*5000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lookup_vld = 1'b0; resolve_vld = 1'b0; resolve_miss = 1'b0;
    in_l1_idx = '0; way_valid = '0; way_l1_idx = '0; rank_order = '0;
    repeat (3) @(negedge clk);
    check("R9 reset vld", {1'b0, victim_vld}, 2'd0);
    rst_n = 1'b1;
    resolve_only(1'b1, "R9 miss after reset");
    // R4: invalid ways win, lowest index first, even over a same-set match
    run_vec(4'b1011, ord(0,1,2,3), idx(5,0,0,0), 3'd5, 1'b1, 1'b1, 2'd2, 2'd2, "R4 way2 empty");
    run_vec(4'b0101, ord(0,1,2,3), idx(0,0,0,0), 3'd0, 1'b1, 1'b1, 2'd1, 2'd2, "R4 lowest empty");
    run_vec(4'b0000, ord(3,2,1,0), idx(0,0,0,0), 3'd1, 1'b1, 1'b1, 2'd0, 2'd2, "R4 all empty");
    // R5: LRU way matches
    run_vec(4'b1111, ord(2,0,3,1), idx(1,1,5,1), 3'd5, 1'b1, 1'b1, 2'd2, 2'd1, "R5 lru match");
    // R6: walk to slot 2, slot 1
    run_vec(4'b1111, ord(3,1,0,2), idx(4,2,4,0), 3'd4, 1'b1, 1'b1, 2'd0, 2'd1, "R6 slot2 match");
    run_vec(4'b1111, ord(0,1,2,3), idx(7,6,6,0), 3'd6, 1'b1, 1'b1, 2'd1, 2'd1, "R6 slot1 match");
    // R7: only the MRU way matches
    run_vec(4'b1111, ord(1,2,3,0), idx(3,0,0,0), 3'd3, 1'b1, 1'b1, 2'd1, 2'd0, "R7 mru excluded");
    // R8: no match at all
    run_vec(4'b1111, ord(2,3,0,1), idx(0,0,0,0), 3'd7, 1'b1, 1'b1, 2'd2, 2'd0, "R8 lru fallback");
    // R3: hit clears the pending lookup; a stray miss then yields nothing
    run_vec(4'b1111, ord(0,1,2,3), idx(1,1,1,1), 3'd1, 1'b0, 1'b0, 2'd0, 2'd0, "R3 hit");
    resolve_only(1'b1, "R3 stray miss");
    // R1/R2: a second miss after a consumed victim yields nothing
    run_vec(4'b1111, ord(3,2,1,0), idx(2,2,2,6), 3'd6, 1'b1, 1'b1, 2'd3, 2'd1, "R1 captured idx");
    resolve_only(1'b1, "R2 no repeat");
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: actual %0d left, expected 0", exp_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule